// File: doc/BRIEF.md
# Machine Clock Source Sequencer

This block decides which of three candidate sources drives the machine clock: the main oscillator, the PLL-multiplied clock, or the low-speed sub-clock. Software writes two select bits, a multiplier code with a range bit, and a wait-time code. The sequencer compares the requested source with the one in use and opens a transition toward it. It then holds that transition until the proper event arrives. Leaving the main oscillator for the PLL waits for the PLL stabilization-done pulse. Leaving the sub-clock waits for the main oscillator stabilization-done pulse. Every other move waits for the synchronization strobe that pairs the two clocks involved.

The outputs feed a glitch-free clock multiplexer and a status view. They give the active mode, the effective PLL multiplication factor, and two display bits that follow the clock actually in use. A busy flag is high while a transition is pending. An error flag is raised when a sub-clock to PLL move starts with a wait-time code that is too short. The multiplexer, the oscillators and the stabilization counters are outside this block.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the block is in main mode (mode 00), multiplier 1, both display bits 1, busy 0, error 0. The stored main-select and sub-select bits are both 1.
- R2: A sub-select bit of 0 wins over any main-select value: the sub-clock is the target, and a PLL stabilization pulse does not complete that move.
- R3: From main mode with main-select 0 and sub-select 1, busy rises one cycle after the write. The mode becomes PLL in the cycle after a PLL stabilization-done pulse, and only then.
- R4: The multiplier is taken from {range, code} when PLL mode is entered. 0/00 gives 1, 0/01 gives 2, 0/10 gives 3, 0/11 gives 4, and 1/10 gives 6. Any other code with range 1 keeps the previous factor.
- R5: From PLL mode, main-select 1 returns the block to main mode only on the PLL/main synchronization strobe.
- R6: From main mode, sub-select 0 enters sub mode only on the main/sub synchronization strobe.
- R7: From sub mode, sub-select 1 with main-select 1 enters main mode after a main stabilization-done pulse.
- R8: From sub mode, sub-select 1 with main-select 0 enters PLL mode directly after a main stabilization-done pulse, and the multiplier is applied as in R4.
- R9: From PLL mode, sub-select 0 enters sub mode only on the PLL/sub synchronization strobe.
- R10: When a sub-to-PLL move starts with a wait code below 2 (binary 00 or 01), the error output goes to 1. It stays at 1 until the next move starts. Codes 10 and 11 leave it at 0.
- R11: Mode encoding is 00 main, 01 PLL, 10 sub. The main display bit is 0 only in PLL mode, and the sub display bit is 0 only in sub mode. While a move is pending, mode and display bits still show the source, and they change only when the move completes.
- R12: Writes made during a pending move are stored but do not abort it, and strobes that do not belong to the pending move are ignored. Once the new stable mode is reached, the stored selects are evaluated again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_main_sel | input | 1 | New main-select bit |
| wr_sub_sel | input | 1 | New sub-select bit |
| wr_mult_code | input | 2 | New multiplier code |
| wr_mult_range | input | 1 | New multiplier range bit |
| wr_wait_code | input | 2 | New stabilization wait-time code |
| pll_stab_done | input | 1 | PLL stabilization finished pulse |
| main_stab_done | input | 1 | Main oscillator stabilization finished pulse |
| sync_pll_main | input | 1 | PLL/main alignment strobe |
| sync_main_sub | input | 1 | Main/sub alignment strobe |
| sync_pll_sub | input | 1 | PLL/sub alignment strobe |
| mode_o | output | 2 | Active clock mode |
| mult_o | output | 3 | Effective PLL multiplication factor |
| main_disp_o | output | 1 | Main display bit |
| sub_disp_o | output | 1 | Sub display bit |
| busy_o | output | 1 | Transition pending |
| wait_err_o | output | 1 | Wait code too short for sub-to-PLL move |

## Verification
If the sequencer takes a wrong state, the mode and display outputs move one cycle after an event that does not belong to the pending move. The other possible result is that they never move at all, and the bench sees that at the next sample after the strobe. A stale or wrong multiplier shows in mult_o in the first cycle of PLL mode. A move that skips its wait can be seen in the busy flag one cycle after the write. A lost re-evaluation can be seen one cycle after a stable mode is reached. The bench therefore also drives strobes from the wrong pair and pulses that arrive too early, and then checks that nothing moved.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
    localparam int CODE_W = 2;
    localparam int WAIT_W = 2;
    localparam int MULT_W = 3;

    typedef enum logic [1:0] {
        MODE_MAIN = 2'b00,
        MODE_PLL  = 2'b01,
        MODE_SUB  = 2'b10
    } clk_mode_e;

    typedef enum logic [3:0] {
        S_MAIN, S_PLL, S_SUB,
        S_M2P, S_P2M, S_M2S, S_S2M, S_S2P, S_P2S
    } seq_state_e;
endpackage

// File: rtl/clkmode_mult_dec.sv
module clkmode_mult_dec #(
    parameter int CODE_W       = 2,
    parameter int MULT_W       = 3,
    parameter int RANGE_CODE   = 2,
    parameter int RANGE_FACTOR = 6
) (
    input  logic              range_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [MULT_W-1:0] factor_o,
    output logic              legal_o
);
    always_comb begin
        if (!range_i) begin
            factor_o = MULT_W'(code_i) + MULT_W'(1);
            legal_o  = 1'b1;
        end else if (code_i == CODE_W'(RANGE_CODE)) begin
            factor_o = MULT_W'(RANGE_FACTOR);
            legal_o  = 1'b1;
        end else begin
            factor_o = '0;
            legal_o  = 1'b0;
        end
    end
endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
    import clkmode_pkg::*;
#(
    parameter int WAIT_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_main_i,
    input  logic              sel_sub_i,
    input  logic [WAIT_W-1:0] wait_code_i,
    input  logic [MULT_W-1:0] factor_i,
    input  logic              legal_i,
    input  logic              pll_stab_i,
    input  logic              main_stab_i,
    input  logic              sync_pm_i,
    input  logic              sync_ms_i,
    input  logic              sync_ps_i,
    output clk_mode_e         mode_o,
    output logic [MULT_W-1:0] mult_o,
    output logic              busy_o,
    output logic              err_o
);
    typedef struct packed {
        seq_state_e        state;
        logic [MULT_W-1:0] mult;
        logic              err;
    } seq_t;

    seq_t      q, d;
    clk_mode_e target;

    always_comb begin
        if (!sel_sub_i)     target = MODE_SUB;
        else if (sel_main_i) target = MODE_MAIN;
        else                target = MODE_PLL;
    end

    always_comb begin
        d = q;
        unique case (q.state)
            S_MAIN: begin
                if (target == MODE_SUB)      begin d.state = S_M2S; d.err = 1'b0; end
                else if (target == MODE_PLL) begin d.state = S_M2P; d.err = 1'b0; end
            end
            S_PLL: begin
                if (target == MODE_SUB)       begin d.state = S_P2S; d.err = 1'b0; end
                else if (target == MODE_MAIN) begin d.state = S_P2M; d.err = 1'b0; end
            end
            S_SUB: begin
                if (target == MODE_MAIN) begin
                    d.state = S_S2M;
                    d.err   = 1'b0;
                end else if (target == MODE_PLL) begin
                    d.state = S_S2P;
                    d.err   = (wait_code_i < WAIT_W'(WAIT_MIN));
                end
            end
            S_M2P: if (pll_stab_i) begin
                d.state = S_PLL;
                if (legal_i) d.mult = factor_i;
            end
            S_S2P: if (main_stab_i) begin
                d.state = S_PLL;
                if (legal_i) d.mult = factor_i;
            end
            S_P2M: if (sync_pm_i)   d.state = S_MAIN;
            S_M2S: if (sync_ms_i)   d.state = S_SUB;
            S_S2M: if (main_stab_i) d.state = S_MAIN;
            S_P2S: if (sync_ps_i)   d.state = S_SUB;
            default: d.state = S_MAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= S_MAIN;
            q.mult  <= MULT_W'(1);
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.state)
            S_PLL, S_P2M, S_P2S: mode_o = MODE_PLL;
            S_SUB, S_S2M, S_S2P: mode_o = MODE_SUB;
            default:             mode_o = MODE_MAIN;
        endcase
    end

    assign busy_o = !(q.state inside {S_MAIN, S_PLL, S_SUB});
    assign mult_o = q.mult;
    assign err_o  = q.err;

    // R4: the stored factor is always one the decoder can produce
    p_mult_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.mult inside {MULT_W'(1), MULT_W'(2), MULT_W'(3), MULT_W'(4), MULT_W'(6)});

    // R12: a pending move ends only in a stable state, never in another wait
    p_no_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && !$stable(q.state)) |-> !busy_o);
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_main_sel,
    input  logic       wr_sub_sel,
    input  logic [1:0] wr_mult_code,
    input  logic       wr_mult_range,
    input  logic [1:0] wr_wait_code,
    input  logic       pll_stab_done,
    input  logic       main_stab_done,
    input  logic       sync_pll_main,
    input  logic       sync_main_sub,
    input  logic       sync_pll_sub,
    output logic [1:0] mode_o,
    output logic [2:0] mult_o,
    output logic       main_disp_o,
    output logic       sub_disp_o,
    output logic       busy_o,
    output logic       wait_err_o
);
    typedef struct packed {
        logic              sel_main;
        logic              sel_sub;
        logic [CODE_W-1:0] code;
        logic              range;
        logic [WAIT_W-1:0] wait_code;
    } regs_t;

    regs_t             r_q, r_d;
    logic [MULT_W-1:0] factor;
    logic              legal;
    clk_mode_e         mode;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.sel_main  = wr_main_sel;
            r_d.sel_sub   = wr_sub_sel;
            r_d.code      = wr_mult_code;
            r_d.range     = wr_mult_range;
            r_d.wait_code = wr_wait_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sel_main  <= 1'b1;
            r_q.sel_sub   <= 1'b1;
            r_q.code      <= '0;
            r_q.range     <= 1'b0;
            r_q.wait_code <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    clkmode_mult_dec #(.CODE_W(CODE_W), .MULT_W(MULT_W)) u_dec (
        .range_i (r_q.range),
        .code_i  (r_q.code),
        .factor_o(factor),
        .legal_o (legal)
    );

    clkmode_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_main_i (r_q.sel_main),
        .sel_sub_i  (r_q.sel_sub),
        .wait_code_i(r_q.wait_code),
        .factor_i   (factor),
        .legal_i    (legal),
        .pll_stab_i (pll_stab_done),
        .main_stab_i(main_stab_done),
        .sync_pm_i  (sync_pll_main),
        .sync_ms_i  (sync_main_sub),
        .sync_ps_i  (sync_pll_sub),
        .mode_o     (mode),
        .mult_o     (mult_o),
        .busy_o     (busy_o),
        .err_o      (wait_err_o)
    );

    assign mode_o      = mode;
    assign main_disp_o = (mode != MODE_PLL);
    assign sub_disp_o  = (mode != MODE_SUB);

    p_pll_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_PLL && $past(mode_o) == MODE_MAIN) |-> $past(pll_stab_done));

    p_pll_to_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_MAIN && $past(mode_o) == MODE_PLL) |-> $past(sync_pll_main));

    p_main_to_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SUB && $past(mode_o) == MODE_MAIN) |-> $past(sync_main_sub));

    // R7 and R8 share this exit condition
    p_sub_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_SUB && $past(mode_o) == MODE_SUB) |-> $past(main_stab_done));

    p_pll_to_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SUB && $past(mode_o) == MODE_PLL) |-> $past(sync_pll_sub));

    p_err_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_err_o) |-> (mode_o == MODE_SUB && busy_o));

    p_disp_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(main_disp_o) || !$stable(sub_disp_o)) |-> $past(busy_o));
endmodule

// File: tb/clkmode_ctrl_bench.sv
module clkmode_ctrl_bench;
    localparam logic [1:0] M_MAIN = 2'b00, M_PLL = 2'b01, M_SUB = 2'b10;
    localparam int ST_PLL = 0, ST_MAIN = 1, SY_PM = 2, SY_MS = 3, SY_PS = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, wr_en = 1'b0, wr_main_sel = 1'b1, wr_sub_sel = 1'b1;
    logic [1:0] wr_mult_code = '0, wr_wait_code = '0;
    logic wr_mult_range = 1'b0;
    logic pll_stab_done = 0, main_stab_done = 0, sync_pll_main = 0, sync_main_sub = 0, sync_pll_sub = 0;
    logic [1:0] mode_o;
    logic [2:0] mult_o;
    logic main_disp_o, sub_disp_o, busy_o, wait_err_o;

    clkmode_ctrl u_clkmode_ctrl (.*);

    typedef struct {
        string      tag;
        logic [7:0] vec;
    } exp_t;
    exp_t sbq[$];

    int total = 0, bad = 0;
    bit finished = 0;
    logic [2:0] exp_mult = 3'd1;
    logic exp_err = 1'b0;

    // monitor: pops expected items and compares with the outputs
    initial forever begin
        exp_t e;
        logic [7:0] act;
        wait (sbq.size() > 0);
        e   = sbq.pop_front();
        act = {mode_o, mult_o, main_disp_o, sub_disp_o, busy_o};
        total++;
        if (act !== e.vec || wait_err_o !== exp_err) begin
            bad++;
            $display("FAIL %s: act mode=%b mult=%0d md=%b sd=%b busy=%b err=%b exp vec=%b err=%b",
                     e.tag, mode_o, mult_o, main_disp_o, sub_disp_o, busy_o, wait_err_o, e.vec, exp_err);
        end
    end

    task automatic expect_now(input string tag, input logic [1:0] m, input logic b);
        exp_t e;
        e.tag = tag;
        e.vec = {m, exp_mult, (m != M_PLL), (m != M_SUB), b};
        sbq.push_back(e);
        #1;
    endtask

    task automatic write_regs(input logic ms, input logic ss, input logic [1:0] code,
                              input logic rng, input logic [1:0] ws);
        @(negedge clk);
        wr_en = 1; wr_main_sel = ms; wr_sub_sel = ss;
        wr_mult_code = code; wr_mult_range = rng; wr_wait_code = ws;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            ST_PLL:  pll_stab_done  = 1;
            ST_MAIN: main_stab_done = 1;
            SY_PM:   sync_pll_main  = 1;
            SY_MS:   sync_main_sub  = 1;
            default: sync_pll_sub   = 1;
        endcase
        @(negedge clk);
        {pll_stab_done, main_stab_done, sync_pll_main, sync_main_sub, sync_pll_sub} = '0;
    endtask

    task automatic go_pll(input logic [1:0] code, input logic rng, input logic [2:0] nm, input string tag);
        write_regs(0, 1, code, rng, 2'b10);
        @(negedge clk);
        expect_now({tag, " pending"}, M_MAIN, 1);
        strobe(ST_PLL);
        exp_mult = nm;
        expect_now({tag, " entered"}, M_PLL, 0);
    endtask

    task automatic go_main(input string tag);
        write_regs(1, 1, 2'b00, 0, 2'b10);
        @(negedge clk);
        expect_now({tag, " pending"}, M_PLL, 1);
        strobe(SY_PM);
        expect_now({tag, " back"}, M_MAIN, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        expect_now("R1 reset", M_MAIN, 0);

        // R3 / R11 / R12: wrong strobe leaves the move pending
        write_regs(0, 1, 2'b10, 0, 2'b00);
        @(negedge clk);
        expect_now("R3 R11 busy source shown", M_MAIN, 1);
        strobe(SY_PM);
        expect_now("R12 foreign strobe ignored", M_MAIN, 1);
        strobe(ST_PLL);
        exp_mult = 3'd3;
        expect_now("R3 R4 pll entered x3", M_PLL, 0);

        // R5 with wrong strobe first
        write_regs(1, 1, 2'b00, 0, 2'b00);
        @(negedge clk);
        expect_now("R5 pending", M_PLL, 1);
        strobe(SY_PS);
        expect_now("R5 pll/sub strobe ignored", M_PLL, 1);
        strobe(SY_PM);
        expect_now("R5 main reached", M_MAIN, 0);

        // R4 codes
        go_pll(2'b01, 0, 3'd2, "R4 code 0/01");
        go_main("R5");
        go_pll(2'b00, 1, 3'd2, "R4 reserved 1/00 holds");
        go_main("R5");
        go_pll(2'b10, 1, 3'd6, "R4 code 1/10");
        go_main("R5");
        go_pll(2'b11, 0, 3'd4, "R4 code 0/11");
        go_main("R5");
        go_pll(2'b00, 0, 3'd1, "R4 code 0/00");
        go_main("R5");

        // R2 / R6: both selects 0 picks sub; PLL stab ignored
        write_regs(0, 0, 2'b11, 0, 2'b00);
        @(negedge clk);
        expect_now("R2 pending toward sub", M_MAIN, 1);
        strobe(ST_PLL);
        expect_now("R2 pll stab ignored", M_MAIN, 1);
        strobe(SY_MS);
        expect_now("R2 R6 R11 sub reached", M_SUB, 0);

        // R7
        write_regs(1, 1, 2'b00, 0, 2'b00);
        @(negedge clk);
        expect_now("R7 pending", M_SUB, 1);
        strobe(SY_MS);
        expect_now("R7 sync strobe ignored", M_SUB, 1);
        strobe(ST_MAIN);
        expect_now("R7 main reached", M_MAIN, 0);

        // back to sub, then R8 / R10 short wait code
        write_regs(1, 0, 2'b00, 0, 2'b00);
        strobe(SY_MS);
        expect_now("R6 sub again", M_SUB, 0);
        write_regs(0, 1, 2'b11, 0, 2'b01);
        @(negedge clk);
        exp_err = 1'b1;
        expect_now("R10 short wait flagged", M_SUB, 1);
        strobe(ST_MAIN);
        exp_mult = 3'd4;
        expect_now("R8 R10 pll direct x4 err held", M_PLL, 0);

        // R9 and error clear
        write_regs(0, 0, 2'b00, 0, 2'b01);
        @(negedge clk);
        exp_err = 1'b0;
        expect_now("R10 cleared on next move", M_PLL, 1);
        strobe(SY_PM);
        expect_now("R9 pll/main strobe ignored", M_PLL, 1);
        strobe(SY_PS);
        expect_now("R9 sub reached", M_SUB, 0);

        // R8 / R10 good wait code, range multiplier
        write_regs(0, 1, 2'b10, 1, 2'b10);
        @(negedge clk);
        expect_now("R10 wait 10 accepted", M_SUB, 1);
        strobe(ST_MAIN);
        exp_mult = 3'd6;
        expect_now("R8 pll x6", M_PLL, 0);

        // R12: write during pending is latched, re-evaluated after arrival
        write_regs(1, 1, 2'b00, 0, 2'b10);
        @(negedge clk);
        expect_now("R12 pending to main", M_PLL, 1);
        write_regs(1, 0, 2'b00, 0, 2'b10);
        expect_now("R12 write does not abort", M_PLL, 1);
        strobe(SY_PM);
        expect_now("R12 main reached first", M_MAIN, 0);
        @(negedge clk);
        expect_now("R12 re-evaluated toward sub", M_MAIN, 1);
        strobe(SY_MS);
        expect_now("R12 sub reached", M_SUB, 0);

        wait (sbq.size() == 0);
        #1;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule